// File: doc/BRIEF.md
# Descriptor Table Register Load/Store Unit

This block holds the base and limit of the global and the interrupt descriptor table registers. It runs the two instructions that move them to or from memory in 16-bit and 32-bit modes. In memory each register takes six bytes: a 16-bit limit at the effective address, and then a 32-bit base. A command carries the effective address, an address-size mask, the operand size, the current privilege level and a table select. The sequencer then makes two accesses on a memory port. The first is a word access for the limit. The second is a dword access for the base, and its address wraps at the address-size boundary.

A load fetches both fields and writes the selected register only after both reads have completed. With a 16-bit operand size, the top byte of the base is discarded. A load issued at a privilege level other than 0 raises a general-protection fault with error code zero, and it makes no memory access. A store writes the current limit and the full base, and it has no privilege check.

Top module: `dtr_ldst_unit`

## Requirements
- R1: After reset both registers hold base 0 and limit 0xFFFF, and done, gp_fault, mem_abort and mem_req are low.
- R2: The first access of every command is a word access (mem_size=0) at cmd_ea. The limit travels in mem_rdata/mem_wdata bits 15:0, and a load ignores bits 31:16.
- R3: The second access is a dword access (mem_size=1) at (cmd_ea + 2) & cmd_amask. For example, ea 0xFFFE with mask 0xFFFF gives address 0x0000.
- R4: A load with cmd_op32=1 and cmd_cpl=0 writes the read limit and the full 32-bit base into the selected register.
- R5: A load with cmd_op32=0 stores the base with bits 31:24 cleared.
- R6: A load with cmd_cpl≠0 pulses gp_fault for one cycle, issues no memory request and changes neither register.
- R7: A store (cmd_store=1) writes the limit and then the full base of the selected register, at any cmd_cpl, and changes neither register.
- R8: cmd_sel=0 selects the global table and cmd_sel=1 selects the interrupt table. The other register is never changed.
- R9: mem_err on either acknowledged access ends the command with a one-cycle mem_abort, no done and no register change.
- R10: done pulses for exactly one cycle, in the cycle after the second access is acknowledged. Commands offered while a command is running are ignored.
- R11: While mem_req waits for mem_ack, mem_addr, mem_size and mem_we stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start a command (taken when idle) |
| cmd_store | input | 1 | 1 = store register to memory, 0 = load |
| cmd_sel | input | 1 | 0 = global table register, 1 = interrupt table register |
| cmd_op32 | input | 1 | 1 = 32-bit operand size |
| cmd_ea | input | AW | Effective address of the six-byte image |
| cmd_amask | input | AW | Address-size mask (0xFFFF or 0xFFFFFFFF) |
| cmd_cpl | input | 2 | Current privilege level |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_size | output | 1 | 0 = word, 1 = dword |
| mem_addr | output | AW | Access address |
| mem_wdata | output | BASE_W | Write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access faulted (valid with mem_ack) |
| mem_rdata | input | BASE_W | Read data (valid with mem_ack) |
| done | output | 1 | Command finished |
| gp_fault | output | 1 | General-protection fault, error code 0 |
| mem_abort | output | 1 | Command ended by a memory fault |
| gdt_base | output | BASE_W | Global table base |
| gdt_limit | output | LIM_W | Global table limit |
| idt_base | output | BASE_W | Interrupt table base |
| idt_limit | output | LIM_W | Interrupt table limit |

## Verification
The bench builds the block with its defaults: 32-bit addresses and base, a 16-bit limit, and the base kept to 24 bits on 16-bit loads. This selects the truncating variant of the base path, so the R5 check can observe the cleared top byte. Using a full 32-bit address with a 16-bit mask makes the wrap of the second address at 0xFFFE observable. With acknowledge latencies of zero to three cycles, the bench can hold a request across wait states and can offer a second command while the first is still running.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
   localparam int unsigned DTR_TABLES = 2;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_LIMIT,
      SQ_BASE,
      SQ_DONE,
      SQ_PRIV,
      SQ_ABORT
   } dtr_state_e;
endpackage

// File: rtl/dtr_regs.sv
module dtr_regs #(
   parameter int unsigned BASE_W    = 32,
   parameter int unsigned LIM_W     = 16,
   parameter int unsigned NUM_TBL   = 2,
   parameter logic [BASE_W-1:0] RST_BASE  = '0,
   parameter logic [LIM_W-1:0]  RST_LIMIT = '1,
   localparam int unsigned SEL_W = (NUM_TBL > 1) ? $clog2(NUM_TBL) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [SEL_W-1:0]               wr_sel,
   input  logic [BASE_W-1:0]              wr_base,
   input  logic [LIM_W-1:0]               wr_limit,
   input  logic [SEL_W-1:0]               rd_sel,
   output logic [BASE_W-1:0]              rd_base,
   output logic [LIM_W-1:0]               rd_limit,
   output logic [NUM_TBL-1:0][BASE_W-1:0] all_base,
   output logic [NUM_TBL-1:0][LIM_W-1:0]  all_limit
);
   initial begin
      assert (NUM_TBL >= 1) else $error("dtr_regs: NUM_TBL must be at least 1");
   end

   for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            all_base[t]  <= RST_BASE;
            all_limit[t] <= RST_LIMIT;
         end else if (wr_en && (wr_sel == SEL_W'(t))) begin
            all_base[t]  <= wr_base;
            all_limit[t] <= wr_limit;
         end
      end

      // R8: a table not addressed by a write keeps its contents
      p_other_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && (wr_sel == SEL_W'(t))) |=> $stable(all_base[t]) && $stable(all_limit[t]))
         else $error("p_other_kept_r8: table %0d changed without a write", t);
   end

   assign rd_base  = all_base[rd_sel];
   assign rd_limit = all_limit[rd_sel];
endmodule

// File: rtl/dtr_seq.sv
module dtr_seq
   import dtr_pkg::*;
#(
   parameter int unsigned AW          = 32,
   parameter int unsigned BASE_W      = 32,
   parameter int unsigned LIM_W       = 16,
   parameter int unsigned KEEP16_BITS = 24,
   parameter int unsigned SEL_W       = 1,
   localparam int unsigned LIM_BYTES  = LIM_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_store,
   input  logic [SEL_W-1:0]  cmd_sel,
   input  logic              cmd_op32,
   input  logic [AW-1:0]     cmd_ea,
   input  logic [AW-1:0]     cmd_amask,
   input  logic [1:0]        cmd_cpl,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_size,
   output logic [AW-1:0]     mem_addr,
   output logic [BASE_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic [BASE_W-1:0] mem_rdata,
   input  logic [BASE_W-1:0] rd_base,
   input  logic [LIM_W-1:0]  rd_limit,
   output logic              wr_en,
   output logic [SEL_W-1:0]  wr_sel,
   output logic [BASE_W-1:0] wr_base,
   output logic [LIM_W-1:0]  wr_limit,
   output logic              done,
   output logic              gp_fault,
   output logic              mem_abort
);
   dtr_state_e        state_q, state_d;
   logic [AW-1:0]     ea_q, ea2_q;
   logic              store_q, op32_q;
   logic [SEL_W-1:0]  sel_q;
   logic [LIM_W-1:0]  lim_q;
   logic              accept, good_ack;
   logic [BASE_W-1:0] base_in;

   assign accept   = (state_q == SQ_IDLE) && cmd_valid;
   assign good_ack = mem_req && mem_ack && !mem_err;

   always_comb begin
      state_d = state_q;
      case (state_q)
         SQ_IDLE:  if (cmd_valid)
                      state_d = (!cmd_store && (cmd_cpl != 2'd0)) ? SQ_PRIV : SQ_LIMIT;
         SQ_LIMIT: if (mem_ack) state_d = mem_err ? SQ_ABORT : SQ_BASE;
         SQ_BASE:  if (mem_ack) state_d = mem_err ? SQ_ABORT : SQ_DONE;
         default:  state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         ea_q    <= '0;
         ea2_q   <= '0;
         store_q <= 1'b0;
         op32_q  <= 1'b0;
         sel_q   <= '0;
         lim_q   <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            ea_q    <= cmd_ea;
            ea2_q   <= (cmd_ea + AW'(LIM_BYTES)) & cmd_amask;
            store_q <= cmd_store;
            op32_q  <= cmd_op32;
            sel_q   <= cmd_sel;
         end
         if ((state_q == SQ_LIMIT) && good_ack) lim_q <= mem_rdata[LIM_W-1:0];
      end
   end

   // Base path variant: trimmed on narrow-operand loads or passed whole
   if (KEEP16_BITS < BASE_W) begin : g_trim
      assign base_in = op32_q ? mem_rdata
                              : {{(BASE_W-KEEP16_BITS){1'b0}}, mem_rdata[KEEP16_BITS-1:0]};
   end else begin : g_whole
      assign base_in = mem_rdata;
   end

   assign mem_req   = (state_q == SQ_LIMIT) || (state_q == SQ_BASE);
   assign mem_size  = (state_q == SQ_BASE);
   assign mem_we    = store_q;
   assign mem_addr  = (state_q == SQ_BASE) ? ea2_q : ea_q;
   assign mem_wdata = (state_q == SQ_BASE) ? rd_base : {{(BASE_W-LIM_W){1'b0}}, rd_limit};

   assign wr_en    = (state_q == SQ_BASE) && good_ack && !store_q;
   assign wr_sel   = sel_q;
   assign wr_base  = base_in;
   assign wr_limit = lim_q;

   assign done      = (state_q == SQ_DONE);
   assign gp_fault  = (state_q == SQ_PRIV);
   assign mem_abort = (state_q == SQ_ABORT);

   // R11: a waiting request holds its attributes
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_size) && $stable(mem_we))
      else $error("p_req_hold_r11");

   // R10: completion strobe lasts one cycle
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("p_done_pulse_r10");

   // R6: a privilege fault makes no memory access
   p_priv_noreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      gp_fault |-> !mem_req && !$past(mem_req)) else $error("p_priv_noreq_r6");

   // R9: outcomes are mutually exclusive
   p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, gp_fault, mem_abort})) else $error("p_one_outcome_r9");

   // R5: a narrow-operand load leaves the top of the base clear
   p_trim_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !op32_q) |=> done && ((rd_base >> KEEP16_BITS) == '0))
      else $error("p_trim_r5");
endmodule

// File: rtl/dtr_ldst_unit.sv
module dtr_ldst_unit
   import dtr_pkg::*;
#(
   parameter int unsigned AW          = 32,
   parameter int unsigned BASE_W      = 32,
   parameter int unsigned LIM_W       = 16,
   parameter int unsigned KEEP16_BITS = 24,
   parameter logic [BASE_W-1:0] RST_BASE  = '0,
   parameter logic [LIM_W-1:0]  RST_LIMIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_store,
   input  logic              cmd_sel,
   input  logic              cmd_op32,
   input  logic [AW-1:0]     cmd_ea,
   input  logic [AW-1:0]     cmd_amask,
   input  logic [1:0]        cmd_cpl,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_size,
   output logic [AW-1:0]     mem_addr,
   output logic [BASE_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   input  logic [BASE_W-1:0] mem_rdata,
   output logic              done,
   output logic              gp_fault,
   output logic              mem_abort,
   output logic [BASE_W-1:0] gdt_base,
   output logic [LIM_W-1:0]  gdt_limit,
   output logic [BASE_W-1:0] idt_base,
   output logic [LIM_W-1:0]  idt_limit
);
   localparam int unsigned SEL_W = 1;

   initial begin
      assert (LIM_W % 8 == 0 && LIM_W < BASE_W) else $error("dtr_ldst_unit: bad LIM_W");
      assert (KEEP16_BITS >= 1 && KEEP16_BITS <= BASE_W) else $error("dtr_ldst_unit: bad KEEP16_BITS");
      assert (AW >= 16) else $error("dtr_ldst_unit: AW too small");
   end

   logic                             wr_en;
   logic [SEL_W-1:0]                 wr_sel;
   logic [BASE_W-1:0]                wr_base, rd_base;
   logic [LIM_W-1:0]                 wr_limit, rd_limit;
   logic [DTR_TABLES-1:0][BASE_W-1:0] all_base;
   logic [DTR_TABLES-1:0][LIM_W-1:0]  all_limit;

   dtr_seq #(
      .AW(AW), .BASE_W(BASE_W), .LIM_W(LIM_W), .KEEP16_BITS(KEEP16_BITS), .SEL_W(SEL_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_store(cmd_store), .cmd_sel(cmd_sel), .cmd_op32(cmd_op32),
      .cmd_ea(cmd_ea), .cmd_amask(cmd_amask), .cmd_cpl(cmd_cpl),
      .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
      .rd_base(rd_base), .rd_limit(rd_limit),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_base(wr_base), .wr_limit(wr_limit),
      .done(done), .gp_fault(gp_fault), .mem_abort(mem_abort)
   );

   dtr_regs #(
      .BASE_W(BASE_W), .LIM_W(LIM_W), .NUM_TBL(DTR_TABLES),
      .RST_BASE(RST_BASE), .RST_LIMIT(RST_LIMIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_base(wr_base), .wr_limit(wr_limit),
      .rd_sel(wr_sel), .rd_base(rd_base), .rd_limit(rd_limit),
      .all_base(all_base), .all_limit(all_limit)
   );

   assign gdt_base  = all_base[0];
   assign gdt_limit = all_limit[0];
   assign idt_base  = all_base[1];
   assign idt_limit = all_limit[1];

   // R4/R9: registers only change in the cycle that announces done
   p_commit_with_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(done) |-> ($stable(all_base) && $stable(all_limit)) || $past(!rst_n))
      else $error("p_commit_with_done_r4");
endmodule

// File: tb/dtr_ldst_unit_tb_top.sv
module dtr_ldst_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_store = 1'b0, cmd_sel = 1'b0, cmd_op32 = 1'b0;
   logic [31:0] cmd_ea = '0, cmd_amask = '0;
   logic [1:0]  cmd_cpl = '0;
   logic        mem_req, mem_we, mem_size;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0, mem_err = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        done, gp_fault, mem_abort;
   logic [31:0] gdt_base, idt_base;
   logic [15:0] gdt_limit, idt_limit;

   int n_checks = 0, n_fail = 0, cycles = 0;

   logic [31:0] lg_addr[4], lg_wdata[4];
   logic        lg_size[4], lg_we[4];
   int  n_acc, last_ack_cyc, done_cyc, req_cycles;
   bit  saw_done, saw_gp, saw_abt;

   always #5 clk = ~clk;

   dtr_ldst_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store), .cmd_sel(cmd_sel),
      .cmd_op32(cmd_op32), .cmd_ea(cmd_ea), .cmd_amask(cmd_amask), .cmd_cpl(cmd_cpl),
      .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
      .done(done), .gp_fault(gp_fault), .mem_abort(mem_abort),
      .gdt_base(gdt_base), .gdt_limit(gdt_limit), .idt_base(idt_base), .idt_limit(idt_limit)
   );

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // Drive one command and act as the memory; intrude offers a second command mid-flight
   task automatic run_cmd(input logic st, input logic sel, input logic op32, input logic [31:0] ea,
                          input logic [31:0] amask, input logic [1:0] cpl, input int lat,
                          input int err_at, input logic [31:0] rd_word, input logic [31:0] rd_dword,
                          input bit intrude);
      int waited;
      bit fin;
      n_acc = 0; waited = 0; fin = 0; req_cycles = 0;
      saw_done = 0; saw_gp = 0; saw_abt = 0; last_ack_cyc = -1; done_cyc = -1;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_store = st; cmd_sel = sel; cmd_op32 = op32;
      cmd_ea = ea; cmd_amask = amask; cmd_cpl = cpl;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int cyc = 0; cyc < 40 && !fin; cyc++) begin
         if (done)      begin saw_done = 1; done_cyc = cyc; fin = 1; end
         if (gp_fault)  begin saw_gp = 1; fin = 1; end
         if (mem_abort) begin saw_abt = 1; fin = 1; end
         if (intrude && cyc == 0) begin
            cmd_valid = 1'b1; cmd_store = 1'b0; cmd_sel = ~sel; cmd_op32 = 1'b1; cmd_cpl = 2'd0;
         end
         if (intrude && cyc == 1) cmd_valid = 1'b0;
         if (mem_req) begin
            req_cycles++;
            if (waited == lat) begin
               if (n_acc < 4) begin
                  lg_addr[n_acc] = mem_addr; lg_size[n_acc] = mem_size;
                  lg_we[n_acc] = mem_we;     lg_wdata[n_acc] = mem_wdata;
               end
               mem_ack = 1'b1;
               mem_err = (n_acc == err_at);
               mem_rdata = (n_acc == 0) ? rd_word : rd_dword;
               last_ack_cyc = cyc;
               n_acc++;
               waited = 0;
            end else waited++;
         end
         @(negedge clk);
         mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = 32'hX5A5_0000 ^ 32'h0;
      end
   endtask

   task automatic t_reset();
      check("R1 gdt base", gdt_base, 32'h0);
      check("R1 gdt limit", {16'h0, gdt_limit}, 32'hFFFF);
      check("R1 idt base", idt_base, 32'h0);
      check("R1 idt limit", {16'h0, idt_limit}, 32'hFFFF);
      check("R1 outputs idle", {28'h0, done, gp_fault, mem_abort, mem_req}, 32'h0);
   endtask

   task automatic t_load_gdt32();
      run_cmd(1'b0, 1'b0, 1'b1, 32'h0000_1000, 32'hFFFF_FFFF, 2'd0, 0, -1,
              32'hDEAD_0123, 32'h89AB_CDEF, 0);
      check("R2 first addr", lg_addr[0], 32'h1000);
      check("R2 first word size", {31'h0, lg_size[0]}, 32'h0);
      check("R2 load is read", {31'h0, lg_we[0]}, 32'h0);
      check("R3 second addr", lg_addr[1], 32'h1002);
      check("R3 second dword size", {31'h0, lg_size[1]}, 32'h1);
      check("R4 gdt limit", {16'h0, gdt_limit}, 32'h0123);
      check("R4 gdt base", gdt_base, 32'h89AB_CDEF);
      check("R8 idt untouched", idt_base, 32'h0);
      check("R10 done seen", {31'h0, saw_done}, 32'h1);
      check("R10 done one cycle after ack", done_cyc - last_ack_cyc, 1);
   endtask

   task automatic t_load_idt16_wrap();
      run_cmd(1'b0, 1'b1, 1'b0, 32'h0000_FFFE, 32'h0000_FFFF, 2'd0, 2, -1,
              32'hBEEF_07FF, 32'h1234_5678, 0);
      check("R3 wrapped addr", lg_addr[1], 32'h0000_0000);
      check("R5 trimmed base", idt_base, 32'h0034_5678);
      check("R4 idt limit", {16'h0, idt_limit}, 32'h07FF);
      check("R8 gdt untouched", gdt_base, 32'h89AB_CDEF);
      check("R11 wait cycles seen", req_cycles, 6);
      check("R10 done after waits", done_cyc - last_ack_cyc, 1);
   endtask

   task automatic t_store_gdt_cpl3();
      run_cmd(1'b1, 1'b0, 1'b0, 32'h0000_2000, 32'hFFFF_FFFF, 2'd3, 1, -1, 32'h0, 32'h0, 0);
      check("R7 store done", {31'h0, saw_done}, 32'h1);
      check("R7 no fault", {31'h0, saw_gp}, 32'h0);
      check("R7 write flag", {30'h0, lg_we[0], lg_we[1]}, 32'h3);
      check("R7 limit data", lg_wdata[0] & 32'hFFFF, 32'h0123);
      check("R7 base data full", lg_wdata[1], 32'h89AB_CDEF);
      check("R7 addresses", lg_addr[1] - lg_addr[0], 2);
      check("R7 gdt unchanged", gdt_base, 32'h89AB_CDEF);
   endtask

   task automatic t_priv_fault();
      run_cmd(1'b0, 1'b0, 1'b1, 32'h3000, 32'hFFFF_FFFF, 2'd2, 0, -1, 32'h1, 32'h2, 0);
      check("R6 gp raised", {31'h0, saw_gp}, 32'h1);
      check("R6 no access", n_acc, 0);
      check("R6 gdt unchanged", gdt_base, 32'h89AB_CDEF);
      check("R6 limit unchanged", {16'h0, gdt_limit}, 32'h0123);
      @(negedge clk);
      check("R6 gp one cycle", {31'h0, gp_fault}, 32'h0);
   endtask

   task automatic t_mem_errors();
      run_cmd(1'b0, 1'b1, 1'b1, 32'h4000, 32'hFFFF_FFFF, 2'd0, 1, 1, 32'h00AA, 32'hCAFE_F00D, 0);
      check("R9 abort on second", {30'h0, saw_abt, saw_done}, 32'h2);
      check("R9 idt base kept", idt_base, 32'h0034_5678);
      check("R9 idt limit kept", {16'h0, idt_limit}, 32'h07FF);
      run_cmd(1'b0, 1'b0, 1'b1, 32'h5000, 32'hFFFF_FFFF, 2'd0, 0, 0, 32'h00BB, 32'h1111_2222, 0);
      check("R9 abort on first", {30'h0, saw_abt, saw_done}, 32'h2);
      check("R9 single access", n_acc, 1);
      check("R9 gdt kept", gdt_base, 32'h89AB_CDEF);
   endtask

   task automatic t_busy_ignore();
      run_cmd(1'b0, 1'b0, 1'b1, 32'h6000, 32'hFFFF_FFFF, 2'd0, 2, -1, 32'h0FFF, 32'h0BAD_0001, 1);
      check("R10 two accesses only", n_acc, 2);
      check("R10 gdt loaded", gdt_base, 32'h0BAD_0001);
      check("R10 idt ignored", idt_base, 32'h0034_5678);
      repeat (3) @(negedge clk);
      check("R10 no second start", {31'h0, mem_req}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_load_gdt32();
      t_load_idt16_wrap();
      t_store_gdt_cpl3();
      t_priv_fault();
      t_mem_errors();
      t_busy_ignore();
      summary();
   end
endmodule